// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Atomic Output Update

The block is a general-purpose I/O port of sixteen pins. Each pin is an input or an output under its own direction bit. The output latch can be written whole, or changed through separate set, clear and toggle addresses. Any group of pins can therefore change in one write while the other pins keep their level.

Incoming pin levels pass through a two-flop synchronizer, then through a per-pin input gate. When a pin is both an output and an enabled input, its receive path takes the value the port is driving instead of the external level. Each pin can raise the port interrupt in one of three ways: while its level is high, on a rising transition, or on any transition. Edge events are held in a sticky status register that software clears by writing ones. Because output pins loop back, software can raise an interrupt by writing the output latch.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset every register (addresses 0 to 9) reads 0, pin_oe and pin_out are 0, and irq is low.
- R2: The direction register at address 0 drives pin_oe bit for bit (1 means output) and reads back at address 0.
- R3: A write to address 1 replaces the whole output latch; the latch drives pin_out and reads back at address 1.
- R4: A write to address 2 sets every output bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to address 3 clears every output bit written as 1 and leaves every bit written as 0 unchanged.
- R6: A write to address 4 inverts every output bit written as 1 and leaves every bit written as 0 unchanged.
- R7: A pin whose bit in the input-enable register (address 5) is 0 reads 0 in the received-level view (read address 10) and raises no event.
- R8: A pin that is both an output and an enabled input reads its own pin_out value at address 10 in the cycle after the write, whatever pin_in carries.
- R9: An external input level applied before a clock edge appears at address 10 after the second following edge, not after the first.
- R10: A pin whose sensitivity bit (address 7) is 0 is level-sensitive: while it is received high and unmasked it holds irq high, and it never sets its status bit.
- R11: A pin in edge mode with its both-edges bit (address 8) at 0 sets its status bit (address 9) on a received 0-to-1 transition only; a 1-to-0 transition leaves the bit at 0.
- R12: A pin in edge mode with its both-edges bit at 1 sets its status bit on either received transition.
- R13: Writing 1 to a bit at address 9 clears that status bit; bits written as 0 stay set, and an edge arriving in the same cycle as the clear leaves the bit set.
- R14: irq is high exactly when some pin with its mask bit (address 6) at 1 has its status bit set or is level-sensitive and received high; status bits latch regardless of mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address (combinational read) |
| rd_data | output | 16 | Read data for rd_addr |
| pin_in | input | 16 | External pin levels |
| pin_out | output | 16 | Output latch toward the pads |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Port interrupt request |

## Verification
The output latch is driven through mixed patterns. Overlapping set, clear and toggle masks separate a true read-modify-write from a plain overwrite. External inputs that disagree with the driven value on output pins show whether loopback takes the pre-pad value, and a level sampled one cycle early exposes a missing synchronizer stage. Rising pulses, falling pulses and software-driven edges on output pins are applied in level, rising-only and both-edge modes, with the mask on and off. A status clear that coincides with a new edge shows which of the two wins.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;
    localparam int ADDR_W = 4;
    // Register address map
    localparam logic [ADDR_W-1:0] A_DIR  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 4'd1;
    localparam logic [ADDR_W-1:0] A_SET  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'd3;
    localparam logic [ADDR_W-1:0] A_TGL  = 4'd4;
    localparam logic [ADDR_W-1:0] A_INEN = 4'd5;
    localparam logic [ADDR_W-1:0] A_MASK = 4'd6;
    localparam logic [ADDR_W-1:0] A_EDGE = 4'd7;
    localparam logic [ADDR_W-1:0] A_BOTH = 4'd8;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd9;
    localparam logic [ADDR_W-1:0] A_PINS = 4'd10;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rx,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] both_sel,
    input  logic [W-1:0] mask,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } evt_t;

    evt_t evt_d, evt_q;
    logic [W-1:0] rise, fall, hit, level, clr;

    always_comb begin
        rise       = rx & ~evt_q.prev;
        fall       = ~rx & evt_q.prev;
        hit        = edge_sel & (rise | (both_sel & fall));
        clr        = clr_en ? clr_bits : '0;
        level      = ~edge_sel & rx;
        evt_d.prev = rx;
        // a new edge wins over a clear in the same cycle
        evt_d.stat = (evt_q.stat & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign status = evt_q.stat;
    assign irq    = |(mask & (evt_q.stat | level));

    // level-sensitive pins never gain a status bit
    assert_level_nolatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q.stat & ~$past(evt_q.stat) & ~$past(edge_sel)) == '0));

    // rising-only pins never latch on a falling transition
    assert_rise_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_q.stat & ~$past(evt_q.stat) & ~$past(both_sel) & ~$past(rx)) == '0));
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_atomic_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] out;
        logic [W-1:0] inen;
        logic [W-1:0] mask;
        logic [W-1:0] edge_sel;
        logic [W-1:0] both;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [W-1:0] pin_sync, rx, status;
    logic         stat_clr;

    gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    // loopback: enabled output pins see the pre-pad value
    assign rx = regs_q.inen & ((regs_q.dir & regs_q.out) | (~regs_q.dir & pin_sync));
    assign stat_clr = wr_en && (wr_addr == A_STAT);

    gpio_evt #(.W(W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx      (rx),
        .edge_sel(regs_q.edge_sel),
        .both_sel(regs_q.both),
        .mask    (regs_q.mask),
        .clr_en  (stat_clr),
        .clr_bits(wr_data),
        .status  (status),
        .irq     (irq)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                A_DIR:   regs_d.dir      = wr_data;
                A_DATA:  regs_d.out      = wr_data;
                A_SET:   regs_d.out      = regs_q.out | wr_data;
                A_CLR:   regs_d.out      = regs_q.out & ~wr_data;
                A_TGL:   regs_d.out      = regs_q.out ^ wr_data;
                A_INEN:  regs_d.inen     = wr_data;
                A_MASK:  regs_d.mask     = wr_data;
                A_EDGE:  regs_d.edge_sel = wr_data;
                A_BOTH:  regs_d.both     = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (rd_addr)
            A_DIR:   rd_data = regs_q.dir;
            A_DATA:  rd_data = regs_q.out;
            A_INEN:  rd_data = regs_q.inen;
            A_MASK:  rd_data = regs_q.mask;
            A_EDGE:  rd_data = regs_q.edge_sel;
            A_BOTH:  rd_data = regs_q.both;
            A_STAT:  rd_data = status;
            A_PINS:  rd_data = rx;
            default: rd_data = '0;
        endcase
    end

    assign pin_out = regs_q.out;
    assign pin_oe  = regs_q.dir;

    assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SET) |=> (pin_out == ($past(pin_out) | $past(wr_data))));
    assert_clr_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CLR) |=> (pin_out == ($past(pin_out) & ~$past(wr_data))));
    assert_tgl_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TGL) |=> (pin_out == ($past(pin_out) ^ $past(wr_data))));
    assert_loopback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SET && (($past(1'b1) == 1'b1))) |=>
        ((rx & regs_q.dir & regs_q.inen & $past(wr_data) & ~$past(wr_en && wr_addr == A_INEN)
          & ~$past(wr_en && wr_addr == A_DIR)) == (regs_q.dir & regs_q.inen & $past(wr_data)
          & ~$past(wr_en && wr_addr == A_INEN) & ~$past(wr_en && wr_addr == A_DIR))));
endmodule

// File: tb/sim_gpio_atomic_port.sv
`timescale 1ns/1ps
module sim_gpio_atomic_port;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_out;
    logic [W-1:0]  pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_atomic_port #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // behavioural reference
    logic [W-1:0] m_dir, m_out, m_inen, m_mask, m_edge, m_both, m_stat, m_prev;
    logic [W-1:0] m_s1, m_s2;

    function automatic logic [W-1:0] m_rx();
        return m_inen & ((m_dir & m_out) | (~m_dir & m_s2));
    endfunction

    function automatic logic m_irq();
        return |(m_mask & (m_stat | (~m_edge & m_rx())));
    endfunction

    function automatic logic [W-1:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_dir;
            4'd1: return m_out;
            4'd5: return m_inen;
            4'd6: return m_mask;
            4'd7: return m_edge;
            4'd8: return m_both;
            4'd9: return m_stat;
            4'd10: return m_rx();
            default: return '0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_inen = '0; m_mask = '0; m_edge = '0;
            m_both = '0; m_stat = '0; m_prev = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            logic [W-1:0] rxv, ev, clrv;
            rxv  = m_rx();
            ev   = m_edge & ((rxv & ~m_prev) | (m_both & ~rxv & m_prev));
            clrv = (wr_en && wr_addr == 4'd9) ? wr_data : '0;
            m_stat = (m_stat & ~clrv) | ev;
            m_prev = rxv;
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_dir  = wr_data;
                    4'd1: m_out  = wr_data;
                    4'd2: m_out  = m_out | wr_data;
                    4'd3: m_out  = m_out & ~wr_data;
                    4'd4: m_out  = m_out ^ wr_data;
                    4'd5: m_inen = wr_data;
                    4'd6: m_mask = wr_data;
                    4'd7: m_edge = wr_data;
                    4'd8: m_both = wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        string rtag;
        rtag = (rd_addr == 4'd10) ? "R8" : (rd_addr == 4'd9) ? "R13" : "R2";
        check("R2 pin_oe", pin_oe, m_dir);
        check("R3 pin_out", pin_out, m_out);
        check("R14 irq", {15'd0, irq}, {15'd0, m_irq()});
        check(rtag, rd_data, m_read(rd_addr));
    endtask

    // one clock: compare at the falling edge, then drive new inputs
    task automatic cyc(input logic we, input logic [3:0] wa, input logic [W-1:0] wd);
        @(negedge clk);
        if (rst_n) compare_model();
        wr_en = we; wr_addr = wa; wr_data = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, '0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        cyc(1'b1, a, d);
        cyc(1'b0, 4'd0, '0);
    endtask

    task automatic peek(input string tag, input logic [3:0] a, input logic [W-1:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        for (int a = 0; a < 10; a++) peek("R1 reset reg", a[3:0], '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq", {15'd0, irq}, '0);

        wr(4'd0, 16'h00FF);
        check("R2 oe", pin_oe, 16'h00FF);
        wr(4'd1, 16'h1234);
        check("R3 write", pin_out, 16'h1234);
        wr(4'd2, 16'h0F00);
        check("R4 set", pin_out, 16'h1F34);
        wr(4'd3, 16'h0034);
        check("R5 clear", pin_out, 16'h1F00);
        wr(4'd4, 16'hFF0F);
        check("R6 toggle", pin_out, 16'hE00F);

        wr(4'd5, 16'hFFFF);
        pin_in = 16'h00AA;
        idle(3);
        peek("R8 loopback", 4'd10, 16'h000F);

        cyc(1'b0, 4'd0, '0);
        pin_in = 16'h55AA;
        cyc(1'b0, 4'd0, '0);
        peek("R9 one edge", 4'd10, 16'h000F);
        cyc(1'b0, 4'd0, '0);
        peek("R9 two edges", 4'd10, 16'h550F);

        wr(4'd5, 16'h00FF);
        peek("R7 disabled", 4'd10, 16'h000F);
        wr(4'd5, 16'hFFFF);

        wr(4'd6, 16'h0100);
        check("R10 level irq", {15'd0, irq}, 16'd1);
        peek("R10 no latch", 4'd9, '0);
        wr(4'd6, 16'h0200);
        check("R14 low pin", {15'd0, irq}, '0);

        wr(4'd7, 16'h0200);
        pin_in = 16'h57AA;
        idle(4);
        peek("R11 rise", 4'd9, 16'h0200);
        check("R14 edge irq", {15'd0, irq}, 16'd1);
        wr(4'd9, 16'h0200);
        peek("R13 w1c", 4'd9, '0);
        pin_in = 16'h55AA;
        idle(4);
        peek("R11 fall ignored", 4'd9, '0);

        wr(4'd8, 16'h0200);
        pin_in = 16'h57AA;
        idle(4);
        peek("R12 rise", 4'd9, 16'h0200);
        wr(4'd9, 16'h0200);
        pin_in = 16'h55AA;
        idle(4);
        peek("R12 fall", 4'd9, 16'h0200);
        wr(4'd9, 16'hFFFF);

        // software edge on output pin 0, with its mask off
        wr(4'd6, 16'h0000);
        wr(4'd7, 16'h0001);
        wr(4'd3, 16'h0001);
        wr(4'd9, 16'h0001);
        wr(4'd2, 16'h0001);
        idle(1);
        peek("R14 latch masked", 4'd9, 16'h0001);
        check("R14 masked irq", {15'd0, irq}, '0);

        // clear in the same cycle as a new edge: edge wins
        wr(4'd8, 16'h0001);
        cyc(1'b1, 4'd4, 16'h0001);
        cyc(1'b1, 4'd9, 16'h0001);
        cyc(1'b0, 4'd0, '0);
        peek("R13 edge wins", 4'd9, 16'h0001);
        wr(4'd9, 16'h0000);
        peek("R13 zero keeps", 4'd9, 16'h0001);

        idle(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule